// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Controller

This block is the bus-master half of an external memory port for an 8-bit processor core. The core hands it one transfer at a time: a 16-bit address, a direction, a flag that picks program space or data space, and, for stores, one byte. The block turns that into a machine cycle on a narrow external bus. The low address byte and the data byte take turns on one shared 8-bit lane, and the upper address byte has its own lines.

Each machine cycle lasts three clocks. In the first clock the address is placed on the shared lane and the active-low address strobe is pulsed. The strobe's rising edge is where an external latch captures the low address, direction and space select. In the second clock the address strobe is released and the active-low data strobe is asserted. For a store, the byte is driven. For a load, the lane is released so memory can drive it. In the third clock the data strobe is released, load data taken at that edge is returned to the core, and a one-clock completion pulse is given. A mode byte from the core decides whether the upper address lines carry the address or are held at zero.

The shared lane is brought out as separate output value, output enable and input value ports. A pad ring or testbench joins them into one wire.

Top module: `mux_bus_ctrl`

## Requirements
- R1: A request is taken on a rising clock edge when `req_valid` and `req_ready` are both 1. `req_ready` is 1 only while idle. `as_n` is low in the clock after acceptance, and `rsp_done` is 1 for exactly one clock, the third clock of the machine cycle.
- R2: `as_n` goes low for exactly one clock, the first clock of each machine cycle, and never outside a machine cycle.
- R3: While `as_n` is low, `ad_oe` is 1 and `ad_out` equals address bits 7..0. `rw` and `dm_n` already hold their cycle values and keep them through the rising edge of `as_n` until the cycle ends.
- R4: `ds_n` goes low for exactly the second clock of each machine cycle. It is never low in the same clock as `as_n`.
- R5: In a store cycle (`req_write` = 1), `ad_oe` is 1 and `ad_out` equals the store byte from the clock where `ds_n` falls through the clock after it rises.
- R6: In a load cycle, `ad_oe` is 0 from the clock after the address clock to the end of the cycle. `rd_data` equals the `ad_in` value present just before `ds_n` rises. `rd_data` is unchanged by store cycles.
- R7: `rw` is 0 during all three clocks of a store cycle and 1 at every other time, including idle.
- R8: `dm_n` is 0 during a cycle with `req_data_space` = 1 (data space) and 1 during a cycle with `req_data_space` = 0 (program space) and while idle.
- R9: `addr_hi` equals address bits 15..8 of the current or last request only when `mode_cfg` bit 7 and bit 1 are both 1. Otherwise it is zero, and it is zero after reset.
- R10: While idle with no request, both strobes stay high, `ad_oe` is 0 and no machine cycle starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Core requests a transfer |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = store, 0 = load |
| req_data_space | input | 1 | 1 = data space, 0 = program space |
| req_addr | input | 16 | Transfer address |
| req_wdata | input | 8 | Store byte |
| mode_cfg | input | 8 | Mode byte; bits 7 and 1 enable the upper address lines |
| rd_data | output | 8 | Last load result |
| rsp_done | output | 1 | One-clock completion pulse |
| ad_out | output | 8 | Shared lane output value |
| ad_oe | output | 1 | Shared lane output enable |
| ad_in | input | 8 | Shared lane input value |
| addr_hi | output | 8 | Upper address byte |
| as_n | output | 1 | Address strobe, active low |
| ds_n | output | 1 | Data strobe, active low |
| rw | output | 1 | 1 = read or idle, 0 = write |
| dm_n | output | 1 | 0 = data space, 1 = program space |

## Verification
A phase register that skips or repeats a state shows up at once at the strobe pins: a second low clock of `as_n` or `ds_n`, or an address strobe with no queued request, is flagged in the clock where it occurs. A wrong latched direction or space shows on `rw` or `dm_n` already in the address clock. A load that captures at the wrong edge returns a deliberately distinct idle pattern and fails at the completion clock. A lane driven during a load is seen in the data-strobe clock, before any data could be corrupted.

// File: rtl/mbc_pkg.sv
// Package: shared phase encoding for the multiplexed bus controller.
// Assumes: a machine cycle is always exactly three clocks (no wait states).
package mbc_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2,
        PH_DONE = 2'd3
    } mbc_phase_e;

    // Returns 1 when both enable bits of the mode byte are set.
    function automatic logic hi_lines_on(input logic bit_a, input logic bit_b);
        return bit_a & bit_b;
    endfunction

endpackage

// File: rtl/mbc_sequencer.sv
// Module: phase sequencer. Walks IDLE -> ADDR -> DATA -> DONE -> IDLE,
// leaving IDLE only on a request. Assumes req_valid is sampled only in IDLE.
module mbc_sequencer
    import mbc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    output mbc_phase_e phase,
    output logic       accept,
    output logic       ready
);

    mbc_phase_e phase_q;

    assign ready  = (phase_q == PH_IDLE);
    assign accept = ready & req_valid;
    assign phase  = phase_q;

    // Advance one phase per clock inside a cycle; wait in IDLE for a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else begin
            unique case (phase_q)
                PH_IDLE: if (req_valid) phase_q <= PH_ADDR;
                PH_ADDR: phase_q <= PH_DATA;
                PH_DATA: phase_q <= PH_DONE;
                PH_DONE: phase_q <= PH_IDLE;
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // R1: a cycle begins exactly one clock after acceptance
    a_r1_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (phase_q == PH_ADDR));

endmodule

// File: rtl/mbc_req_latch.sv
// Module: holds the accepted request for the whole machine cycle.
// Assumes accept is a single-clock qualifier from the sequencer.
module mbc_req_latch #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_data_space,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [ADDR_W-1:0] lat_addr,
    output logic              lat_write,
    output logic              lat_dspace,
    output logic [DATA_W-1:0] lat_wdata
);

    // Capture the request fields on acceptance; keep them until the next one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_addr   <= '0;
            lat_write  <= 1'b0;
            lat_dspace <= 1'b0;
            lat_wdata  <= '0;
        end else if (accept) begin
            lat_addr   <= req_addr;
            lat_write  <= req_write;
            lat_dspace <= req_data_space;
            lat_wdata  <= req_wdata;
        end
    end

endmodule

// File: rtl/mbc_bus_drive.sv
// Module: decodes the phase and latched request into the external pins:
// strobes, direction, space select, shared lane and upper address byte.
// Assumes the phase comes straight from a register, so decode depth is one gate level.
module mbc_bus_drive
    import mbc_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter int MODE_W   = 8,
    parameter int HI_BIT_A = 7,
    parameter int HI_BIT_B = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mbc_phase_e        phase,
    input  logic [ADDR_W-1:0] lat_addr,
    input  logic              lat_write,
    input  logic              lat_dspace,
    input  logic [DATA_W-1:0] lat_wdata,
    input  logic [MODE_W-1:0] mode_cfg,
    output logic              as_n,
    output logic              ds_n,
    output logic              rw,
    output logic              dm_n,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [ADDR_W-DATA_W-1:0] addr_hi
);

    localparam int HI_W = ADDR_W - DATA_W;

    logic in_cycle;
    logic in_data;
    logic hi_en;
    logic mode_unused;

    assign in_cycle    = (phase != PH_IDLE);
    assign in_data     = (phase == PH_DATA) | (phase == PH_DONE);
    assign hi_en       = hi_lines_on(mode_cfg[HI_BIT_A], mode_cfg[HI_BIT_B]);
    assign mode_unused = ^mode_cfg;

    // Strobes, direction and space select from the current phase.
    always_comb begin
        as_n = (phase != PH_ADDR);
        ds_n = (phase != PH_DATA);
        rw   = ~(in_cycle & lat_write);
        dm_n = ~(in_cycle & lat_dspace);
    end

    // Shared lane: address in ADDR, store byte in DATA/DONE, released otherwise.
    always_comb begin
        ad_out = '0;
        ad_oe  = 1'b0;
        if (phase == PH_ADDR) begin
            ad_out = lat_addr[DATA_W-1:0];
            ad_oe  = 1'b1;
        end else if (in_data && lat_write) begin
            ad_out = lat_wdata;
            ad_oe  = 1'b1;
        end
    end

    // Upper address lines gated by the mode byte, zero when disabled.
    generate
        if (HI_W > 0) begin : g_hi
            always_comb addr_hi = hi_en ? lat_addr[ADDR_W-1:DATA_W] : '0;
        end
    endgenerate

    // R2: address strobe low for one clock only
    a_r2_as_single: assert property (@(posedge clk) disable iff (!rst_n)
        !as_n |=> as_n);

    // R4: data strobe falls right after the address clock
    a_r4_ds_after_as: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ds_n) |-> $past(!as_n));

    // R4: the strobes never overlap
    a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(!as_n && !ds_n));

    // R6: no lane drive while memory drives during a load
    a_r6_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        (!ds_n && rw) |-> !ad_oe);

    // R5: store byte still driven in the clock after data strobe rises
    a_r5_hold_after_ds: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ds_n) && !rw) |-> (ad_oe && ad_out == lat_wdata));

    // R7: direction held for the whole store cycle
    a_r7_rw_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!as_n) |=> $stable(rw));

endmodule

// File: rtl/mbc_rd_capture.sv
// Module: captures load data at the data-strobe rising edge and raises the
// completion pulse. Assumes ad_in is stable before the end of the DATA phase.
module mbc_rd_capture
    import mbc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mbc_phase_e        phase,
    input  logic              lat_write,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] rd_data,
    output logic              done
);

    logic take;

    assign take = (phase == PH_DATA) & ~lat_write;

    // Latch load data at the edge that ends the data strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (take) begin
            rd_data <= ad_in;
        end
    end

    // One-clock completion pulse during the last clock of the cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= (phase == PH_DATA);
    end

    // R1: completion is a single-clock pulse
    a_r1_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: a store leaves the load result untouched
    a_r6_store_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DATA && lat_write) |=> $stable(rd_data));

endmodule

// File: rtl/mux_bus_ctrl.sv
// Module: top of the multiplexed address/data bus controller. Joins the
// sequencer, request latch, pin decode and load capture. Assumes the core
// holds mode_cfg steady during a cycle and issues one request at a time.
module mux_bus_ctrl
    import mbc_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter int MODE_W   = 8,
    parameter int HI_BIT_A = 7,
    parameter int HI_BIT_B = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_data_space,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [MODE_W-1:0] mode_cfg,
    output logic [DATA_W-1:0] rd_data,
    output logic              rsp_done,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    input  logic [DATA_W-1:0] ad_in,
    output logic [ADDR_W-DATA_W-1:0] addr_hi,
    output logic              as_n,
    output logic              ds_n,
    output logic              rw,
    output logic              dm_n
);

    mbc_phase_e        phase;
    logic              accept;
    logic [ADDR_W-1:0] lat_addr;
    logic              lat_write;
    logic              lat_dspace;
    logic [DATA_W-1:0] lat_wdata;

    mbc_sequencer u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .phase     (phase),
        .accept    (accept),
        .ready     (req_ready)
    );

    mbc_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_lat (
        .clk            (clk),
        .rst_n          (rst_n),
        .accept         (accept),
        .req_addr       (req_addr),
        .req_write      (req_write),
        .req_data_space (req_data_space),
        .req_wdata      (req_wdata),
        .lat_addr       (lat_addr),
        .lat_write      (lat_write),
        .lat_dspace     (lat_dspace),
        .lat_wdata      (lat_wdata)
    );

    mbc_bus_drive #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MODE_W(MODE_W),
        .HI_BIT_A(HI_BIT_A), .HI_BIT_B(HI_BIT_B)
    ) u_drv (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase      (phase),
        .lat_addr   (lat_addr),
        .lat_write  (lat_write),
        .lat_dspace (lat_dspace),
        .lat_wdata  (lat_wdata),
        .mode_cfg   (mode_cfg),
        .as_n       (as_n),
        .ds_n       (ds_n),
        .rw         (rw),
        .dm_n       (dm_n),
        .ad_out     (ad_out),
        .ad_oe      (ad_oe),
        .addr_hi    (addr_hi)
    );

    mbc_rd_capture #(.DATA_W(DATA_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase),
        .lat_write (lat_write),
        .ad_in     (ad_in),
        .rd_data   (rd_data),
        .done      (rsp_done)
    );

    // R10: no strobe activity while ready and idle
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (as_n && ds_n && !ad_oe && rw && dm_n));

    // R1: done only follows a data strobe
    a_r1_done_after_ds: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> $past(!ds_n));

endmodule

// File: tb/mux_bus_ctrl_bench.sv
module mux_bus_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic        req_data_space = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  mode_cfg = '0;
    logic [7:0]  rd_data;
    logic        rsp_done;
    logic [7:0]  ad_out;
    logic        ad_oe;
    logic [7:0]  ad_in;
    logic [7:0]  addr_hi;
    logic        as_n, ds_n, rw, dm_n;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [15:0] addr;
        logic        wr;
        logic        dsp;
        logic [7:0]  wd;
        logic        hien;
    } item_t;

    item_t q[$];
    item_t cur;
    int    ph = 0;
    logic [15:0] seen_addr = '0;
    logic        seen_dsp = 1'b0;
    logic [7:0]  wcap = '0;
    logic [7:0]  last_rd = '0;

    always #5 clk = ~clk;

    mux_bus_ctrl u_mux_bus_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_data_space(req_data_space),
        .req_addr(req_addr), .req_wdata(req_wdata), .mode_cfg(mode_cfg),
        .rd_data(rd_data), .rsp_done(rsp_done), .ad_out(ad_out), .ad_oe(ad_oe),
        .ad_in(ad_in), .addr_hi(addr_hi), .as_n(as_n), .ds_n(ds_n), .rw(rw),
        .dm_n(dm_n)
    );

    function automatic logic [7:0] mem_val(input logic [15:0] a, input logic d);
        return a[7:0] ^ a[15:8] ^ (d ? 8'h3C : 8'hC3);
    endfunction

    // Memory model: drives the lane only while a load holds the data strobe.
    assign ad_in = (!ds_n && rw) ? mem_val(seen_addr, seen_dsp) : 8'hEE;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Scoreboard monitor, sampling away from the rising edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (!as_n) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R2 unexpected address strobe", 0, 1);
                    cur = '{16'h0, 1'b0, 1'b0, 8'h0, 1'b0};
                end else begin
                    cur = q.pop_front();
                end
                seen_addr = {addr_hi, ad_out};
                seen_dsp  = ~dm_n;
                chk(ad_oe && ad_out == cur.addr[7:0], "R3 low address", ad_out, cur.addr[7:0]);
                chk(rw == !cur.wr, "R7 rw in address clock", rw, !cur.wr);
                chk(dm_n == !cur.dsp, "R8 dm_n in address clock", dm_n, !cur.dsp);
                chk(addr_hi == (cur.hien ? cur.addr[15:8] : 8'h00), "R9 upper address",
                    addr_hi, cur.hien ? cur.addr[15:8] : 8'h00);
                chk(ds_n && !req_ready, "R4 ds high and busy in address clock", ds_n, 1);
                ph = 1;
            end else if (ph == 1) begin
                chk(!ds_n, "R4 data strobe low in second clock", ds_n, 0);
                chk(rw == !cur.wr && dm_n == !cur.dsp, "R3 rw/dm held",
                    {rw, dm_n}, {!cur.wr, !cur.dsp});
                if (cur.wr) begin
                    chk(ad_oe && ad_out == cur.wd, "R5 store byte at ds fall", ad_out, cur.wd);
                    wcap = ad_out;
                end else begin
                    chk(!ad_oe, "R6 lane released during load", ad_oe, 0);
                end
                ph = 2;
            end else if (ph == 2) begin
                chk(rsp_done && ds_n, "R1 done in third clock", rsp_done, 1);
                chk(rw == !cur.wr, "R7 rw held in third clock", rw, !cur.wr);
                if (cur.wr) begin
                    chk(ad_oe && ad_out == cur.wd && wcap == cur.wd, "R5 store byte held",
                        ad_out, cur.wd);
                    chk(rd_data == last_rd, "R6 load result kept over store", rd_data, last_rd);
                end else begin
                    chk(!ad_oe, "R6 lane released in third clock", ad_oe, 0);
                    chk(rd_data == mem_val(seen_addr, cur.dsp), "R6 load data",
                        rd_data, mem_val(seen_addr, cur.dsp));
                    last_rd = mem_val(seen_addr, cur.dsp);
                end
                ph = 0;
            end else begin
                chk(ds_n && !rsp_done && rw && dm_n && !ad_oe, "R10 idle pins",
                    {ds_n, rsp_done, rw, dm_n, ad_oe}, 5'b10110);
            end
        end
    end

    // Driver: offers one request, pushes its expected item, checks start latency.
    task automatic do_txn(input logic [15:0] a, input logic wr, input logic dsp,
                          input logic [7:0] wd, input logic [7:0] mode);
        item_t it;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        mode_cfg       = mode;
        req_addr       = a;
        req_write      = wr;
        req_data_space = dsp;
        req_wdata      = wd;
        req_valid      = 1'b1;
        it = '{a, wr, dsp, wd, mode[7] & mode[1]};
        q.push_back(it);
        @(negedge clk);
        req_valid = 1'b0;
        chk(!as_n, "R1 address strobe one clock after accept", as_n, 0);
        chk(!req_ready, "R1 ready low in cycle", req_ready, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(as_n && ds_n && rw && dm_n && !ad_oe && !rsp_done && req_ready,
            "R10 reset pins", {as_n, ds_n, rw, dm_n, ad_oe, rsp_done}, 6'b111100);
        chk(addr_hi == 8'h00 && rd_data == 8'h00, "R9 reset upper byte", addr_hi, 0);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(as_n && req_ready, "R10 no cycle without request", as_n, 1);
        do_txn(16'h12A5, 1'b0, 1'b0, 8'h00, 8'h82);
        do_txn(16'hBEEF, 1'b1, 1'b1, 8'h5A, 8'h82);
        do_txn(16'h3456, 1'b0, 1'b1, 8'h00, 8'h00);
        do_txn(16'h7F01, 1'b1, 1'b0, 8'hC3, 8'h00);
        do_txn(16'hFFFF, 1'b0, 1'b0, 8'h00, 8'h80);
        do_txn(16'hA0A0, 1'b0, 1'b1, 8'h00, 8'h02);
        do_txn(16'h0000, 1'b0, 1'b1, 8'h00, 8'hFF);
        do_txn(16'h8001, 1'b1, 1'b1, 8'hFF, 8'hFF);
        do_txn(16'hC3C3, 1'b0, 1'b0, 8'h00, 8'h82);
        do_txn(16'h5511, 1'b1, 1'b0, 8'h00, 8'h82);
        repeat (8) @(negedge clk);
        chk(q.size() == 0, "R2 every request produced a cycle", q.size(), 0);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule